// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block sits behind the vector instruction decoder. It decides whether an already classified vector instruction must raise an illegal-instruction exception. The decoder supplies a class vector, the register numbers of the destination and both sources, and the mask bit. The block also takes the current vector type state (the invalid flag, the element width and the group multiplier), the element width encoded in a load/store, and the current start index.

Eight independent rules are evaluated combinationally and captured in one register stage. The registered result is a single illegal flag plus an eight-bit cause vector for debug. Each rule carries its own exemptions. A configuration-setting (vset) instruction is exempt from everything except the reserved-encoding rule. A load/store is exempt from the start-index rule.

Encodings used throughout:
- Element width code `vt_sew`: 0=8, 1=16, 2=32, 3=64 bits. `ls_eew` uses the same codes.
- Multiplier code `vt_lmul` is read as a signed 3-bit log2: 0..3 mean 1,2,4,8; 5,6,7 mean 1/8,1/4,1/2; 4 is reserved.
- An effective multiplier with log2 `m > 0` spans `2^m` registers and must start on a multiple of `2^m`.

Top module: `vlegal_check`

## Requirements
- R1: A class vector with bit 8 (reserved) set yields cause bit 0 one cycle later. This applies whatever the other inputs are.
- R2: When `vt_vill` is 1 and class bit 0 (vset) is clear, cause bit 1 is set.
- R3: When `vstart` is nonzero and neither class bit 0 (vset) nor bit 1 (load/store) is set, cause bit 7 is set. A load/store with nonzero `vstart` does not set it.
- R4: Cause bit 2 (element width) is set in any of these cases:
  - floating-point (bit 7) with SEW code 0;
  - widening (bit 2) or narrowing (bit 3) with SEW code 3;
  - sign/zero extension by a factor of 2^k (bits 4/5/6 give k=1/2/3) with SEW code below k.
- R5: Cause bit 3 (multiplier range) is set in any of these cases:
  - the multiplier code is 4;
  - a widening or narrowing instruction has log2 LMUL + 1 above 3;
  - an extension has log2 LMUL − k below −3;
  - a load/store has EMUL = EEW code − SEW code + log2 LMUL outside −3..3;
  - a 16-bit-index gather (bit 9) has 1 − SEW code + log2 LMUL outside −3..3.
- R6: Cause bit 4 is set when any group is misaligned to its effective multiplier. The effective multiplier is taken as follows:
  - vd: log2 LMUL+1 when widening, EMUL when load/store, otherwise log2 LMUL;
  - vs2, checked only if bit 11 is set: log2 LMUL+1 when narrowing, log2 LMUL−k when extending, otherwise log2 LMUL;
  - vs1, checked only if bit 10 is set: the gather EMUL when bit 9 is set, otherwise log2 LMUL.
- R7: A masked instruction (`in_vm`=0) with `in_vd`=0 sets cause bit 5.
- R8: With class bit 12 (no-overlap) set, cause bit 6 is set when the vd group overlaps the vs1 group (if bit 10 is set) or the vs2 group (if bit 11 is set).
- R9: `out_illegal` is the OR of the eight cause bits. Both `out_illegal` and `out_cause` are registered on the cycle `in_valid` is high. `out_valid` follows `in_valid` by one cycle.
- R10: With class bit 0 (vset) set, cause bits 1 to 7 stay 0 for any other inputs.
- R11: After reset, `out_valid`, `out_illegal` and `out_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_cls | input | 13 | Class bits as listed in the requirements |
| in_vm | input | 1 | Mask bit, 0 = masked |
| in_vd | input | 5 | Destination register |
| in_vs1 | input | 5 | Source register 1 |
| in_vs2 | input | 5 | Source register 2 |
| vt_vill | input | 1 | Vector type invalid |
| vt_sew | input | 2 | Element width code |
| vt_lmul | input | 3 | Signed log2 multiplier code |
| ls_eew | input | 2 | Load/store element width code |
| vstart | input | VSTART_W | Current start index |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Exception required |
| out_cause | output | 8 | Per-rule cause bits |

## Verification
The bench aims at the exemption boundaries. A vset carrying every other fault must report nothing but a reserved encoding. A design that forgets an exemption shows a stray cause bit there. A load/store with nonzero start index must pass, which catches a start-index rule applied too widely.

Group arithmetic is probed at its edges:
- a widening destination that overlaps its source by one register;
- a narrowing source group that is only half aligned;
- a load/store whose EMUL reaches 16.

A design computing group size from the plain multiplier would miss the overlap and the misalignment. A design with an off-by-one range test would accept the oversized EMUL. Multi-fault inputs check that cause bits combine rather than mask one another.

// File: rtl/vlegal_check.sv
module vlegal_check #(
  parameter int VSTART_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [12:0]         in_cls,
  input  logic                in_vm,
  input  logic [4:0]          in_vd,
  input  logic [4:0]          in_vs1,
  input  logic [4:0]          in_vs2,
  input  logic                vt_vill,
  input  logic [1:0]          vt_sew,
  input  logic [2:0]          vt_lmul,
  input  logic [1:0]          ls_eew,
  input  logic [VSTART_W-1:0] vstart,
  output logic                out_valid,
  output logic                out_illegal,
  output logic [7:0]          out_cause
);
  localparam int C_VSET = 0, C_LDST = 1, C_WIDEN = 2, C_NARROW = 3;
  localparam int C_EXT2 = 4, C_EXT4 = 5, C_EXT8 = 6, C_FP = 7;
  localparam int C_RSV = 8, C_G16 = 9, C_S1G = 10, C_S2G = 11, C_NOOV = 12;

  function automatic logic misal(input logic [4:0] r, input logic signed [4:0] em);
    logic [4:0] mask;
    mask = (em > 5'sd0) ? ((5'd1 << em[2:0]) - 5'd1) : 5'd0;
    return (r & mask) != 5'd0;
  endfunction

  function automatic logic [5:0] gsz(input logic signed [4:0] em);
    return (em > 5'sd0) ? (6'd1 << em[2:0]) : 6'd1;
  endfunction

  function automatic logic ovl(input logic [4:0] a, input logic signed [4:0] ea,
                               input logic [4:0] b, input logic signed [4:0] eb);
    return ({1'b0, a} < ({1'b0, b} + gsz(eb))) && ({1'b0, b} < ({1'b0, a} + gsz(ea)));
  endfunction

  logic signed [4:0] lm, s, e, ek, em_ls, em_g16, em_d, em_s1, em_s2;
  logic is_ext, wn, chk;
  logic [7:0] cause_n;

  assign lm     = {{2{vt_lmul[2]}}, vt_lmul};
  assign s      = {3'b000, vt_sew};
  assign e      = {3'b000, ls_eew};
  assign is_ext = in_cls[C_EXT2] | in_cls[C_EXT4] | in_cls[C_EXT8];
  assign ek     = in_cls[C_EXT8] ? 5'sd3 : in_cls[C_EXT4] ? 5'sd2 : in_cls[C_EXT2] ? 5'sd1 : 5'sd0;
  assign wn     = in_cls[C_WIDEN] | in_cls[C_NARROW];
  assign chk    = ~in_cls[C_VSET];

  assign em_ls  = e - s + lm;
  assign em_g16 = 5'sd1 - s + lm;
  assign em_d   = in_cls[C_WIDEN] ? lm + 5'sd1 : in_cls[C_LDST] ? em_ls : lm;
  assign em_s2  = in_cls[C_NARROW] ? lm + 5'sd1 : is_ext ? lm - ek : lm;
  assign em_s1  = in_cls[C_G16] ? em_g16 : lm;

  assign cause_n[0] = in_cls[C_RSV];
  assign cause_n[1] = chk & vt_vill;
  assign cause_n[2] = chk & ((in_cls[C_FP] & (s == 5'sd0)) |
                             (wn & (s == 5'sd3)) |
                             (is_ext & (s < ek)));
  assign cause_n[3] = chk & ((vt_lmul == 3'd4) |
                             (wn & (lm + 5'sd1 > 5'sd3)) |
                             (is_ext & (lm - ek < -5'sd3)) |
                             (in_cls[C_LDST] & ((em_ls > 5'sd3) | (em_ls < -5'sd3))) |
                             (in_cls[C_G16] & ((em_g16 > 5'sd3) | (em_g16 < -5'sd3))));
  assign cause_n[4] = chk & (misal(in_vd, em_d) |
                             (in_cls[C_S1G] & misal(in_vs1, em_s1)) |
                             (in_cls[C_S2G] & misal(in_vs2, em_s2)));
  assign cause_n[5] = chk & ~in_vm & (in_vd == 5'd0);
  assign cause_n[6] = chk & in_cls[C_NOOV] &
                      ((in_cls[C_S1G] & ovl(in_vd, em_d, in_vs1, em_s1)) |
                       (in_cls[C_S2G] & ovl(in_vd, em_d, in_vs2, em_s2)));
  assign cause_n[7] = chk & ~in_cls[C_LDST] & (vstart != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_cause   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cause   <= cause_n;
        out_illegal <= |cause_n;
      end
    end
  end
endmodule

module vlegal_check_sva #(
  parameter int VSTART_W = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [12:0]         in_cls,
  input logic                in_vm,
  input logic [4:0]          in_vd,
  input logic                vt_vill,
  input logic [VSTART_W-1:0] vstart,
  input logic                out_valid,
  input logic                out_illegal,
  input logic [7:0]          out_cause
);
  a_r9_flag_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_illegal == (|out_cause)));
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cls[8]) |=> out_cause[0]);
  a_r2_vill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vt_vill && !in_cls[0]) |=> out_cause[1]);
  a_r3_vstart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vstart != '0 && !in_cls[0] && !in_cls[1]) |=> out_cause[7]);
  a_r7_v0_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_cls[0] && !in_vm && in_vd == 5'd0) |=> out_cause[5]);
  a_r10_vset_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cls[0]) |=> (out_cause[7:1] == 7'd0));
endmodule

bind vlegal_check vlegal_check_sva #(.VSTART_W(VSTART_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls), .in_vm(in_vm),
  .in_vd(in_vd), .vt_vill(vt_vill), .vstart(vstart), .out_valid(out_valid),
  .out_illegal(out_illegal), .out_cause(out_cause));

// File: tb/vlegal_check_test.sv
module vlegal_check_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_vm = 1, vt_vill = 0;
  logic [12:0] in_cls = '0;
  logic [4:0] in_vd = '0, in_vs1 = '0, in_vs2 = '0;
  logic [1:0] vt_sew = '0, ls_eew = '0;
  logic [2:0] vt_lmul = '0;
  logic [6:0] vstart = '0;
  logic out_valid, out_illegal;
  logic [7:0] out_cause;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [12:0] VSET = 13'h1, LDST = 13'h2, WID = 13'h4, NAR = 13'h8;
  localparam logic [12:0] EXT4 = 13'h20, FP = 13'h80, RSV = 13'h100;
  localparam logic [12:0] S1G = 13'h400, S2G = 13'h800, NOOV = 13'h1000;

  always #4 clk = ~clk;

  vlegal_check uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_vm(in_vm), .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2), .vt_vill(vt_vill),
    .vt_sew(vt_sew), .vt_lmul(vt_lmul), .ls_eew(ls_eew), .vstart(vstart),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_cause(out_cause));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [12:0] c, logic vm, logic [4:0] vd, logic [4:0] s1,
                     logic [4:0] s2, logic vill, logic [1:0] sew, logic [2:0] lmul,
                     logic [1:0] eew, logic [6:0] vst, logic [7:0] exp);
    @(negedge clk);
    in_valid = 1; in_cls = c; in_vm = vm; in_vd = vd; in_vs1 = s1; in_vs2 = s2;
    vt_vill = vill; vt_sew = sew; vt_lmul = lmul; ls_eew = eew; vstart = vst;
    @(negedge clk);
    in_valid = 0;
    check(req, {24'd0, out_cause}, {24'd0, exp});
    check({req, "/R9"}, {31'd0, out_illegal}, {31'd0, |exp});
  endtask

  task automatic t_reset;
    check("R11 valid", {31'd0, out_valid}, 0);
    check("R11 illegal", {31'd0, out_illegal}, 0);
    check("R11 cause", {24'd0, out_cause}, 0);
  endtask

  task automatic t_legal;
    run("R6 legal aligned", S1G|S2G, 1, 4, 8, 12, 0, 2, 3'd2, 0, 0, 8'h00);
  endtask
  task automatic t_reserved;
    run("R1 reserved", RSV, 1, 1, 0, 0, 0, 0, 0, 0, 0, 8'h01);
  endtask
  task automatic t_vill;
    run("R2 vill", 0, 1, 1, 0, 0, 1, 0, 0, 0, 0, 8'h02);
    run("R2 vill+R3 vstart", 0, 1, 1, 0, 0, 1, 0, 0, 0, 7'd3, 8'h82);
  endtask
  task automatic t_vstart;
    run("R3 vstart", 0, 1, 1, 0, 0, 0, 0, 0, 0, 7'd5, 8'h80);
    run("R3 ldst exempt", LDST, 1, 1, 0, 0, 0, 0, 0, 0, 7'd5, 8'h00);
  endtask
  task automatic t_eew;
    run("R4 fp sew8", FP, 1, 1, 0, 0, 0, 0, 0, 0, 0, 8'h04);
    run("R4 widen sew64", WID, 1, 2, 0, 0, 0, 3, 0, 0, 0, 8'h04);
    run("R4 ext4 sew16", EXT4, 1, 1, 0, 0, 0, 1, 0, 0, 0, 8'h04);
  endtask
  task automatic t_emul;
    run("R5 widen lmul8", WID, 1, 0, 0, 0, 0, 0, 3'd3, 0, 0, 8'h08);
    run("R5 ldst emul16", LDST, 1, 16, 0, 0, 0, 0, 3'd1, 3, 0, 8'h08);
    run("R5 lmul code4", 0, 1, 0, 0, 0, 0, 0, 3'd4, 0, 0, 8'h08);
  endtask
  task automatic t_align;
    run("R6 vd odd lmul2", 0, 1, 3, 0, 0, 0, 0, 3'd1, 0, 0, 8'h10);
    run("R6 vs2 lmul4", S2G, 1, 4, 0, 5, 0, 0, 3'd2, 0, 0, 8'h10);
    run("R6 narrow vs2", NAR|S2G, 1, 0, 0, 2, 0, 0, 3'd1, 0, 0, 8'h10);
  endtask
  task automatic t_v0;
    run("R7 masked v0", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h20);
    run("R7 masked v8 ok", 0, 0, 8, 0, 0, 0, 0, 0, 0, 0, 8'h00);
  endtask
  task automatic t_overlap;
    run("R8 widen overlap", WID|S2G|NOOV, 1, 4, 0, 5, 0, 0, 0, 0, 0, 8'h40);
    run("R8 widen adjacent", WID|S2G|NOOV, 1, 4, 0, 6, 0, 0, 0, 0, 0, 8'h00);
  endtask
  task automatic t_vset;
    run("R10 vset exempt", VSET, 0, 0, 0, 0, 1, 0, 3'd4, 0, 7'd9, 8'h00);
    run("R10 vset reserved", VSET|RSV, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h01);
  endtask
  task automatic t_valid;
    @(negedge clk);
    check("R9 idle valid", {31'd0, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_legal(); t_reserved(); t_vill(); t_vstart(); t_eew(); t_emul();
    t_align(); t_v0(); t_overlap(); t_vset(); t_valid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule